// File: doc/BRIEF.md
# USB Host Controller Global Register File

This block is the global control and status register space of a USB host controller. A simple word-oriented register bus selects a register by byte offset. The offset is relative to the window where the block sits, which is 0xC100 inside the controller's address space. Only whole, aligned 32-bit words are accessed, and bit 0 of the data is bit 0 of the register. Each register keeps a read-only mask, so a write changes only the bits outside that mask. In the status register, two flag bits are set by event inputs and cleared when software writes a one to them.

The identity word, the user-ID word and nine hardware-parameter words have fixed values. The first parameter word carries the controller mode in its low bits. Writing the control register with bit 11 set starts a core soft reset. One clock later, the bus, user-control-1 and frame-adjust registers return to their reset values. Control, status, GPIO and user control keep their contents. Bit 11 clears itself, and the attached host core receives a one-cycle reset pulse.

Top module: `usb_glb_regs`

## Requirements
- R1: Read data is combinational. With `bus_sel` high, `bus_rdata` shows the word at the aligned offset `bus_addr` in the same cycle. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are high. Control is at 0x010 and is fully writable.
- R2: A write updates only the bits outside the register's read-only mask. The read-only bits keep their values. The masks and results are as follows:
  - Offset 0x000 has mask 0x0000F300. Writing all ones reads back 0xFFFF0CFF.
  - Offset 0x004 has mask 0xFFFFE0FF and resets to 0x300. Writing all ones reads back 0x1F00, and a following write of zero reads back 0.
  - Offset 0x01C has mask 0x7800 and resets to 0x198A. Writing zero reads back 0x1800.
  - Offset 0x024 has mask 0x0000FFFF and resets to 0. Writing 0xABCD1234 reads back 0xABCD0000.
  - Offset 0x02C has mask 0x001C8000. Writing zero reads back 0x8000.
  - Offset 0x530 has mask 0x00400040. Writing all ones reads back 0xFFBFFFBF.
- R3: Status is at 0x018 and resets to 0x7E800000. Only bits 5:4 can change. `status_evt[0]` sets bit 4 and `status_evt[1]` sets bit 5. Writing a one to either bit clears it. If a set and a clear of the same bit fall in one cycle, the set wins.
- R4: The ID word at 0x020 reads 0x5533330A and ignores writes. The parameter words are fixed:
  - 0x040 reads 0x40204048 OR `MODE`, which is 0x40204049 for host mode 1.
  - 0x044 reads 0x0222493B.
  - 0x05C reads 0.
  - 0x500 reads 0x478.
- R5: The user-ID word at 0x028 always reads `USER_ID`, which defaults to 0x12345678, whatever data is written to it.
- R6: A write to control with bit 11 set makes control read with bit 11 set for one cycle. At the next edge, offset 0x000 returns to 0, 0x004 to 0x300, 0x01C to 0x198A and 0x530 to 0x0C83F020, and bit 11 clears.
- R7: A soft reset leaves status, GPIO, user control and control bits other than bit 11 unchanged.
- R8: `core_rst` is high for exactly the one cycle between a soft-reset write and the edge where the reset takes effect. It stays low after power-on reset.
- R9: Unmapped offsets and misaligned offsets, where `bus_addr[1:0]` is not 0, read 0. Writes to them change no register.
- R10: `rst_n` low restores every writable register to its reset value:
  - control to 0x30C13004;
  - user control to 0x0C808010;
  - frame adjust to 0x0C83F020;
  - the other reset values as listed in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the global window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| status_evt | input | 2 | Set pulses for status bits 4 and 5 |
| core_rst | output | 1 | One-cycle reset pulse to the host core |

## Verification
The assertions assume that a control write with bit 11 set is not followed by another control write in the very next cycle. Such a rewrite would legally stretch the reset pulse. The assertions also assume that the status events are synchronous to `clk`. The stimulus issues only one access at a time, with idle cycles between accesses. It changes the event inputs only at falling edges. It therefore never rewrites control during a pulse.

// File: rtl/usb_glb_regs.sv
module usb_glb_regs #(
  parameter int          ADDR_W  = 12,
  parameter logic [31:0] USER_ID = 32'h1234_5678,
  parameter logic [2:0]  MODE    = 3'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [1:0]        status_evt,
  output logic              core_rst
);
  localparam logic [31:0] BC0_RST = 32'h0,         BC0_RO = 32'h0000_F300;
  localparam logic [31:0] BC1_RST = 32'h0000_0300, BC1_RO = 32'hFFFF_E0FF;
  localparam logic [31:0] CTL_RST = 32'h30C1_3004;
  localparam logic [31:0] STS_RST = 32'h7E80_0000;
  localparam logic [31:0] UC1_RST = 32'h0000_198A, UC1_RO = 32'h0000_7800;
  localparam logic [31:0] GPIO_RO = 32'h0000_FFFF;
  localparam logic [31:0] UC_RST  = 32'h0C80_8010, UC_RO  = 32'h001C_8000;
  localparam logic [31:0] FLA_RST = 32'h0C83_F020, FLA_RO = 32'h0040_0040;
  localparam logic [31:0] ID_VAL  = 32'h5533_330A;
  localparam logic [31:0] HW0_VAL = 32'h4020_4048 | {29'd0, MODE};

  function automatic logic [31:0] mwr(input logic [31:0] old, input logic [31:0] d,
                                      input logic [31:0] ro);
    return (old & ro) | (d & ~ro);
  endfunction

  logic [31:0] bc0_q, bc1_q, ctl_q, uc1_q, gpio_q, uc_q, fla_q;
  logic [1:0]  flag_q;
  logic        wr_en, srst;

  assign wr_en = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00);
  assign srst  = ctl_q[11];
  assign core_rst = srst;

  wire we_bc0  = wr_en && bus_addr == ADDR_W'('h000);
  wire we_bc1  = wr_en && bus_addr == ADDR_W'('h004);
  wire we_ctl  = wr_en && bus_addr == ADDR_W'('h010);
  wire we_sts  = wr_en && bus_addr == ADDR_W'('h018);
  wire we_uc1  = wr_en && bus_addr == ADDR_W'('h01C);
  wire we_gpio = wr_en && bus_addr == ADDR_W'('h024);
  wire we_uc   = wr_en && bus_addr == ADDR_W'('h02C);
  wire we_fla  = wr_en && bus_addr == ADDR_W'('h530);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc0_q <= BC0_RST; bc1_q <= BC1_RST; uc1_q <= UC1_RST; fla_q <= FLA_RST;
    end else if (srst) begin
      bc0_q <= BC0_RST; bc1_q <= BC1_RST; uc1_q <= UC1_RST; fla_q <= FLA_RST;
    end else begin
      if (we_bc0) bc0_q <= mwr(bc0_q, bus_wdata, BC0_RO);
      if (we_bc1) bc1_q <= mwr(bc1_q, bus_wdata, BC1_RO);
      if (we_uc1) uc1_q <= mwr(uc1_q, bus_wdata, UC1_RO);
      if (we_fla) fla_q <= mwr(fla_q, bus_wdata, FLA_RO);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= CTL_RST;
      gpio_q <= '0;
      uc_q   <= UC_RST;
      flag_q <= STS_RST[5:4];
    end else begin
      if (we_ctl)    ctl_q <= bus_wdata;
      else if (srst) ctl_q[11] <= 1'b0;
      if (we_gpio) gpio_q <= mwr(gpio_q, bus_wdata, GPIO_RO);
      if (we_uc)   uc_q   <= mwr(uc_q, bus_wdata, UC_RO);
      flag_q <= (flag_q & ~(we_sts ? bus_wdata[5:4] : 2'b00)) | status_evt;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && bus_addr[1:0] == 2'b00) begin
      case (bus_addr)
        ADDR_W'('h000): bus_rdata = bc0_q;
        ADDR_W'('h004): bus_rdata = bc1_q;
        ADDR_W'('h010): bus_rdata = ctl_q;
        ADDR_W'('h018): bus_rdata = {STS_RST[31:6], flag_q, STS_RST[3:0]};
        ADDR_W'('h01C): bus_rdata = uc1_q;
        ADDR_W'('h020): bus_rdata = ID_VAL;
        ADDR_W'('h024): bus_rdata = gpio_q;
        ADDR_W'('h028): bus_rdata = USER_ID;
        ADDR_W'('h02C): bus_rdata = uc_q;
        ADDR_W'('h040): bus_rdata = HW0_VAL;
        ADDR_W'('h044): bus_rdata = 32'h0222_493B;
        ADDR_W'('h048): bus_rdata = 32'h1234_5678;
        ADDR_W'('h04C): bus_rdata = 32'h0618_C088;
        ADDR_W'('h050): bus_rdata = 32'h4782_2004;
        ADDR_W'('h054): bus_rdata = 32'h0420_2088;
        ADDR_W'('h058): bus_rdata = 32'h0785_0C20;
        ADDR_W'('h05C): bus_rdata = 32'h0;
        ADDR_W'('h500): bus_rdata = 32'h0000_0478;
        ADDR_W'('h530): bus_rdata = fla_q;
        default:        bus_rdata = '0;
      endcase
    end
  end

  AST_RO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    we_bc1 && !srst |=> (bc1_q & BC1_RO) == $past(bc1_q & BC1_RO)); // R2
  AST_STS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    we_sts && bus_wdata[4] && !status_evt[0] |=> !flag_q[0]); // R3
  AST_STS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    status_evt[1] |=> flag_q[1]); // R3
  AST_SRST_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> bc0_q == BC0_RST && bc1_q == BC1_RST && uc1_q == UC1_RST && fla_q == FLA_RST); // R6
  AST_SRST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst && !wr_en |=> $stable(gpio_q) && $stable(uc_q) && $stable(ctl_q[31:12])); // R7
  AST_SRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst && !we_ctl |=> !core_rst); // R8
endmodule

// File: tb/usb_glb_regs_tb.sv
module usb_glb_regs_tb;
  logic clk = 0, rst_n = 0, bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [1:0]  status_evt = '0;
  logic        core_rst;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  usb_glb_regs u_dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .status_evt(status_evt), .core_rst(core_rst));

  localparam int NV = 14;
  localparam logic [11:0] VA [NV] = '{12'h000, 12'h004, 12'h004, 12'h01C, 12'h01C, 12'h024,
    12'h02C, 12'h530, 12'h020, 12'h028, 12'h010, 12'h008, 12'h040, 12'h500};
  localparam logic [31:0] VD [NV] = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0, 32'hFFFFFFFF,
    32'hABCD1234, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hDEADBEEF, 32'h0, 32'hFFFFFFFF,
    32'h0, 32'h0};
  localparam logic [31:0] VE [NV] = '{32'hFFFF0CFF, 32'h00001F00, 32'h0, 32'h00001800,
    32'hFFFF9FFF, 32'hABCD0000, 32'h00008000, 32'hFFBFFFBF, 32'h5533330A, 32'h12345678,
    32'h0, 32'h0, 32'h40204049, 32'h00000478};
  localparam string VR [NV] = '{"R2", "R2", "R2", "R2", "R2", "R2", "R2", "R2", "R4", "R5",
    "R1", "R9", "R4", "R4"};

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(string req, logic [11:0] a, logic [31:0] exp);
    bus_sel = 1; bus_wr = 0; bus_addr = a; #1;
    chk(req, bus_rdata, exp);
    bus_sel = 0;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd("R10", 12'h010, 32'h30C13004);
    rd("R10", 12'h004, 32'h00000300);
    chk("R8", {31'd0, core_rst}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      wr(VA[i], VD[i]);
      rd(VR[i], VA[i], VE[i]);
    end

    wr(12'h011, 32'hFFFFFFFF);
    rd("R9", 12'h010, 32'h0);
    rd("R9", 12'h012, 32'h0);

    @(negedge clk); status_evt = 2'b01;
    @(negedge clk); status_evt = 2'b00;
    rd("R3", 12'h018, 32'h7E800010);
    @(negedge clk); status_evt = 2'b10; bus_sel = 1; bus_wr = 1; bus_addr = 12'h018;
    bus_wdata = 32'h20;
    @(negedge clk); status_evt = 2'b00; bus_sel = 0; bus_wr = 0;
    rd("R3", 12'h018, 32'h7E800030);
    wr(12'h018, 32'h00000020);
    rd("R3", 12'h018, 32'h7E800010);

    wr(12'h010, 32'h12340800);
    chk("R8", {31'd0, core_rst}, 32'd1);
    rd("R6", 12'h010, 32'h12340800);
    @(negedge clk);
    chk("R8", {31'd0, core_rst}, 32'd0);
    rd("R6", 12'h010, 32'h12340000);
    rd("R6", 12'h000, 32'h0);
    rd("R6", 12'h004, 32'h00000300);
    rd("R6", 12'h01C, 32'h0000198A);
    rd("R6", 12'h530, 32'h0C83F020);
    rd("R7", 12'h024, 32'hABCD0000);
    rd("R7", 12'h02C, 32'h00008000);
    rd("R7", 12'h018, 32'h7E800010);
    rd("R4", 12'h044, 32'h0222493B);
    @(negedge clk);
    chk("R8", {31'd0, core_rst}, 32'd0);

    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd("R10", 12'h010, 32'h30C13004);
    rd("R10", 12'h02C, 32'h0C808010);
    rd("R10", 12'h024, 32'h0);
    rd("R10", 12'h018, 32'h7E800000);
    rd("R10", 12'h530, 32'h0C83F020);
    rd("R10", 12'h01C, 32'h0000198A);
    rd("R4", 12'h05C, 32'h0);
    chk("R8", {31'd0, core_rst}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule